// File: doc/BRIEF.md
# DSP Condition Flag Generator

This block derives one condition flag from the outcome of a DSP ALU or shifter operation and holds it in a register. The datapath hands it a guarded result word (a 32-bit destination field with 8 guard bits above it), the ALU carry or borrow, the last bit shifted out, a signed over-range indication for the full guarded width, and the class of the operation. A 3-bit mode selects which condition the flag follows.

The flag can follow carry, sign, zero, destination overflow, or one of two signed comparisons against zero. The block does not compute the result, decode instructions or gate conditional execution. Downstream logic reads the registered flag and decides for itself what it means.

Top module: `dsp_cond_flag`

## Requirements
- R1: A synchronous active-high reset (`rst`) clears `flag` to 0 on the next clock edge.
- R2: `flag` changes only on a clock edge where `upd` is 1. When `upd` is 0 it keeps its value.
- R3: Mode 000 follows carry. The classes on `op_class` are 00 arithmetic ALU, 01 logical ALU, 10 arithmetic shift and 11 logical shift. Class 00 loads `carry`, both shift classes load `shift_out`, and class 01 loads 0.
- R4: Mode 001 follows the sign. Classes 00 and 10 load `result[39]`, and classes 01 and 11 load `result[31]`.
- R5: Mode 010 follows zero. Class 01 loads 1 when `result[31:0]` is all zeros. Every other class loads 1 when all 40 bits of `result` are zeros. Otherwise the flag loads 0.
- R6: Mode 011 follows destination overflow. Classes 00 and 10 load 1 unless `result[39:31]` are all equal. Classes 01 and 11 load 0.
- R7: Mode 101 is greater-or-equal. Classes 00 and 10 load NOT(`result[39]` XOR `ovf_full`). Classes 01 and 11 load 0.
- R8: Mode 100 is greater-than. Classes 00 and 10 load NOT((`result[39]` XOR `ovf_full`) OR the 40-bit result is zero). Classes 01 and 11 load 0.
- R9: Modes 110 and 111 are reserved. An update in either mode leaves `flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd | input | 1 | Update strobe: load the flag on this edge |
| mode | input | 3 | Condition mode select |
| op_class | input | 2 | Operation class of the current result |
| result | input | 40 | Guarded result word (guard bits 39:32, destination 31:0) |
| carry | input | 1 | ALU carry or borrow |
| shift_out | input | 1 | Last bit shifted out by the shifter |
| ovf_full | input | 1 | Result exceeds the full 40-bit signed range |
| flag | output | 1 | Registered condition flag |

## Verification
The flag is the block's only state. A wrong rule or a wrong guard-bit slice shows on `flag` one cycle after the offending update. The bench compares against its model on every edge, so it sees the error in that same cycle. An update that should have been blocked shows the same way: a load while `upd` is low or in a reserved mode corrupts a value that must stay constant, and the next comparison catches it. Directed results at the 32-bit boundary and full 40-bit over-range cases expose off-by-one slicing, which random data reaches only rarely.

// File: rtl/dsp_flag_pkg.sv
package dsp_flag_pkg;

  typedef enum logic [1:0] {
    OP_ARITH  = 2'b00,
    OP_LOGIC  = 2'b01,
    OP_ASHIFT = 2'b10,
    OP_LSHIFT = 2'b11
  } op_class_e;

  typedef enum logic [2:0] {
    MD_CARRY = 3'd0,
    MD_NEG   = 3'd1,
    MD_ZERO  = 3'd2,
    MD_OVF   = 3'd3,
    MD_GT    = 3'd4,
    MD_GE    = 3'd5,
    MD_RSV6  = 3'd6,
    MD_RSV7  = 3'd7
  } flag_mode_e;

  // Result properties computed once and shared by every mode rule
  typedef struct packed {
    logic neg_full;   // sign of the guarded word
    logic neg_dest;   // sign of the destination field
    logic zero_full;  // whole guarded word is zero
    logic zero_dest;  // destination field is zero
    logic dest_ovf;   // value does not fit the destination field
  } res_feat_t;

endpackage

// File: rtl/dsp_flag_feats.sv
module dsp_flag_feats
  import dsp_flag_pkg::*;
#(
  parameter int DEST_W  = 32,
  parameter int GUARD_W = 8,
  localparam int RES_W  = DEST_W + GUARD_W
) (
  input  logic [RES_W-1:0] result,
  output res_feat_t        feat
);

  // Upper bits that must all match the destination sign for the value to fit
  localparam int TOP_W = GUARD_W + 1;

  logic [TOP_W-1:0] top_bits;

  assign top_bits = result[RES_W-1:DEST_W-1];

  always_comb begin
    feat.neg_full  = result[RES_W-1];
    feat.neg_dest  = result[DEST_W-1];
    feat.zero_dest = ~|result[DEST_W-1:0];
    feat.zero_full = feat.zero_dest & ~|result[RES_W-1:DEST_W];
    feat.dest_ovf  = ~((&top_bits) | ~(|top_bits));
  end

endmodule

// File: rtl/dsp_flag_rule.sv
module dsp_flag_rule
  import dsp_flag_pkg::*;
(
  input  flag_mode_e mode,
  input  op_class_e  op_class,
  input  res_feat_t  feat,
  input  logic       carry,
  input  logic       shift_out,
  input  logic       ovf_full,
  output logic       load,
  output logic       next_flag
);

  logic is_logic;  // logical ALU or logical shift
  logic sgn_ge;

  assign is_logic = (op_class == OP_LOGIC) || (op_class == OP_LSHIFT);
  assign sgn_ge   = ~(feat.neg_full ^ ovf_full);

  always_comb begin
    load      = 1'b1;
    next_flag = 1'b0;
    unique case (mode)
      MD_CARRY: begin
        unique case (op_class)
          OP_ARITH:             next_flag = carry;
          OP_ASHIFT, OP_LSHIFT: next_flag = shift_out;
          default:              next_flag = 1'b0;
        endcase
      end
      MD_NEG:  next_flag = is_logic ? feat.neg_dest : feat.neg_full;
      MD_ZERO: next_flag = (op_class == OP_LOGIC) ? feat.zero_dest : feat.zero_full;
      MD_OVF:  next_flag = ~is_logic & feat.dest_ovf;
      MD_GT:   next_flag = ~is_logic & sgn_ge & ~feat.zero_full;
      MD_GE:   next_flag = ~is_logic & sgn_ge;
      default: load      = 1'b0;
    endcase
  end

endmodule

// File: rtl/dsp_cond_flag.sv
module dsp_cond_flag
  import dsp_flag_pkg::*;
#(
  parameter int DEST_W  = 32,
  parameter int GUARD_W = 8,
  localparam int RES_W  = DEST_W + GUARD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [2:0]       mode,
  input  logic [1:0]       op_class,
  input  logic [RES_W-1:0] result,
  input  logic             carry,
  input  logic             shift_out,
  input  logic             ovf_full,
  output logic             flag
);

  res_feat_t feat;
  logic      rule_load;
  logic      rule_flag;

  dsp_flag_feats #(
    .DEST_W (DEST_W),
    .GUARD_W(GUARD_W)
  ) u_feats (
    .result(result),
    .feat  (feat)
  );

  dsp_flag_rule u_rule (
    .mode     (flag_mode_e'(mode)),
    .op_class (op_class_e'(op_class)),
    .feat     (feat),
    .carry    (carry),
    .shift_out(shift_out),
    .ovf_full (ovf_full),
    .load     (rule_load),
    .next_flag(rule_flag)
  );

  always_ff @(posedge clk) begin
    if (rst)                   flag <= 1'b0;
    else if (upd && rule_load) flag <= rule_flag;
  end

endmodule

// File: rtl/dsp_cond_flag_chk.sv
module dsp_cond_flag_chk #(
  parameter int RES_W = 40
) (
  input logic             clk,
  input logic             rst,
  input logic             upd,
  input logic [2:0]       mode,
  input logic [1:0]       op_class,
  input logic [RES_W-1:0] result,
  input logic             flag
);

  a_r1_reset_clear: assert property (@(posedge clk) rst |=> !flag);

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(flag));

  a_r3_logic_alu_clear: assert property (@(posedge clk) disable iff (rst)
    (upd && mode == 3'd0 && op_class == 2'b01) |=> !flag);

  a_r4_guarded_sign: assert property (@(posedge clk) disable iff (rst)
    (upd && mode == 3'd1 && !op_class[0]) |=> (flag == $past(result[RES_W-1])));

  a_r5_zero_sets: assert property (@(posedge clk) disable iff (rst)
    (upd && mode == 3'd2 && result == '0) |=> flag);

  a_r6_logic_no_ovf: assert property (@(posedge clk) disable iff (rst)
    (upd && mode == 3'd3 && op_class[0]) |=> !flag);

  a_r7_logic_ge_clear: assert property (@(posedge clk) disable iff (rst)
    (upd && mode == 3'd5 && op_class[0]) |=> !flag);

  a_r8_gt_zero_clear: assert property (@(posedge clk) disable iff (rst)
    (upd && mode == 3'd4 && result == '0) |=> !flag);

  a_r9_reserved_hold: assert property (@(posedge clk) disable iff (rst)
    (upd && mode[2:1] == 2'b11) |=> $stable(flag));

endmodule

bind dsp_cond_flag dsp_cond_flag_chk #(.RES_W(RES_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .upd     (upd),
  .mode    (mode),
  .op_class(op_class),
  .result  (result),
  .flag    (flag)
);

// File: tb/dsp_cond_flag_tb.sv
module dsp_cond_flag_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  op_class = '0;
  logic [39:0] result = '0;
  logic        carry = 1'b0;
  logic        shift_out = 1'b0;
  logic        ovf_full = 1'b0;
  logic        flag;

  int   checks = 0;
  int   fails  = 0;
  logic exp    = 1'b0;
  bit   done   = 1'b0;

  always #2 clk = ~clk;

  dsp_cond_flag u_dut (
    .clk(clk), .rst(rst), .upd(upd), .mode(mode), .op_class(op_class),
    .result(result), .carry(carry), .shift_out(shift_out),
    .ovf_full(ovf_full), .flag(flag)
  );

  function automatic string req_of(input logic u, input logic [2:0] m);
    if (!u) return "R2";
    case (m)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R8";
      3'd5: return "R7";
      default: return "R9";
    endcase
  endfunction

  // Behavioural model working on the numeric value of the result
  function automatic logic model(input logic prev, input logic u, input logic [2:0] m,
                                 input logic [1:0] oc, input logic [39:0] r,
                                 input logic c, input logic s, input logic o);
    longint v;
    bit     arith;
    bit     neg;
    v     = $signed(r);
    arith = (oc == 2'b00) || (oc == 2'b10);
    neg   = (v < 0);
    if (!u) return prev;
    case (m)
      3'd0: return (oc == 2'b01) ? 1'b0 : (oc == 2'b00) ? c : s;
      3'd1: return arith ? neg : r[31];
      3'd2: return (oc == 2'b01) ? (r[31:0] == 32'd0) : (v == 0);
      3'd3: return arith && !(v >= -(64'sd1 <<< 31) && v < (64'sd1 <<< 31));
      3'd4: return arith && !((neg ^ o) || v == 0);
      3'd5: return arith && !(neg ^ o);
      default: return prev;
    endcase
  endfunction

  task automatic check(input string req, input logic want);
    checks++;
    if (flag !== want) begin
      fails++;
      $display("FAIL %s: flag=%b expected=%b (mode=%0d class=%0d result=%h)",
               req, flag, want, mode, op_class, result);
    end
  endtask

  task automatic step(input logic u, input logic [2:0] m, input logic [1:0] oc,
                      input logic [39:0] r, input logic c, input logic s, input logic o);
    @(negedge clk);
    upd = u; mode = m; op_class = oc; result = r;
    carry = c; shift_out = s; ovf_full = o;
    exp = model(exp, u, m, oc, r, c, s, o);
    @(posedge clk);
    #1;
    check(req_of(u, m), exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    exp = 1'b0;
    check("R1", exp);
    @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [39:0] pick_result();
    logic [63:0] w;
    w = {$urandom(), $urandom()};
    case ($urandom % 5)
      0: return w[39:0];
      1: return 40'd0;
      2: return 40'($signed(w[31:0]));
      3: return 40'h00_8000_0000 + 40'($signed(w[3:0]));
      default: return {w[39:32] & 8'h01 ? 8'hFF : 8'h00, w[31:0]};
    endcase
  endfunction

  initial begin
    do_reset();

    // R1 also after the flag has been set
    step(1, 3'd0, 2'b00, 40'd5, 1, 0, 0);
    do_reset();

    // R3: carry, shifted-out bit, logical clear
    step(1, 3'd0, 2'b00, 40'd1, 1, 0, 0);
    step(1, 3'd0, 2'b11, 40'd1, 0, 1, 0);
    step(1, 3'd0, 2'b01, 40'd1, 1, 1, 0);
    step(1, 3'd0, 2'b10, 40'd1, 1, 0, 0);
    // R2: strobe low keeps a set flag
    step(1, 3'd0, 2'b00, 40'd1, 1, 0, 0);
    step(0, 3'd0, 2'b01, 40'd0, 0, 0, 0);
    step(0, 3'd3, 2'b00, 40'h00_8000_0000, 0, 0, 0);
    // R4: guard sign vs destination sign
    step(1, 3'd1, 2'b00, 40'h00_8000_0000, 0, 0, 0);
    step(1, 3'd1, 2'b01, 40'h00_8000_0000, 0, 0, 0);
    step(1, 3'd1, 2'b10, 40'hFF_0000_0001, 0, 0, 0);
    step(1, 3'd1, 2'b11, 40'hFF_0000_0001, 0, 0, 0);
    // R5: all-zero results, logical uses destination field only
    step(1, 3'd2, 2'b00, 40'd0, 0, 0, 0);
    step(1, 3'd2, 2'b01, 40'h12_0000_0000, 0, 0, 0);
    step(1, 3'd2, 2'b10, 40'h12_0000_0000, 0, 0, 0);
    step(1, 3'd2, 2'b11, 40'd0, 0, 0, 0);
    // R6: just outside the 32-bit range, and edges just inside
    step(1, 3'd3, 2'b00, 40'h00_8000_0000, 0, 0, 0);
    step(1, 3'd3, 2'b00, 40'h00_7FFF_FFFF, 0, 0, 0);
    step(1, 3'd3, 2'b10, 40'hFF_7FFF_FFFF, 0, 0, 0);
    step(1, 3'd3, 2'b00, 40'hFF_8000_0000, 0, 0, 0);
    step(1, 3'd3, 2'b01, 40'h00_8000_0000, 0, 0, 0);
    // R7 / R8: full 40-bit over-range flips the sign sense
    step(1, 3'd5, 2'b00, 40'h80_0000_0000, 0, 0, 1);
    step(1, 3'd5, 2'b00, 40'h80_0000_0000, 0, 0, 0);
    step(1, 3'd5, 2'b11, 40'h00_0000_0001, 0, 0, 0);
    step(1, 3'd4, 2'b10, 40'h7F_FFFF_FFFF, 0, 0, 1);
    step(1, 3'd4, 2'b00, 40'd0, 0, 0, 0);
    step(1, 3'd4, 2'b00, 40'd7, 0, 0, 0);
    step(1, 3'd5, 2'b00, 40'd0, 0, 0, 0);
    // R9: reserved modes hold both values
    step(1, 3'd6, 2'b00, 40'd0, 0, 0, 0);
    step(1, 3'd7, 2'b01, 40'd0, 1, 1, 1);
    step(1, 3'd2, 2'b00, 40'd3, 0, 0, 0);
    step(1, 3'd6, 2'b00, 40'd0, 1, 1, 0);

    // Random sweep over every mode and class
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 8) != 0, 3'($urandom), 2'($urandom), pick_result(),
           1'($urandom), 1'($urandom), ($urandom % 4) == 0);
      if (i % 1000 == 999) do_reset();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule